// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a 7-bit addressed I2C target that runs from a fast system clock. It brings the SCL and SDA pad inputs into the clock domain through synchronizers and finds START and STOP conditions and clock edges there. After each START it shifts in an address byte and compares it with a programmable own address, and with the general-call address when that is enabled. On a match it acknowledges and then either takes in write data or sends read data through a single byte buffer. The pads are open drain, so the block only ever pulls a line low, and it shows this as two output-enable signals.

Software reaches the block through a small register port with four locations: data buffer, own address, control and status. The block never overwrites a byte that software has not yet collected. When the buffer is still full, or an overflow is still pending, it withholds the acknowledge and flags an overflow instead. It can hold SCL low until software has served the transfer. A release bit in the control register drives this hold: hardware clears the bit at the end of a byte, and software sets it again to let the bus run.

Top module: `i2c_target`

## Requirements
- R1: Register offsets: 0 data buffer, 1 own address (bits 6:0), 2 control, 3 status. Control bits: 0 enable, 1 clock release, 2 stretch enable, 3 general-call enable, 4 START/STOP interrupt enable. Status bits: 0 buffer full, 1 overflow, 2 write collision, 3 interrupt, 4 last byte was data, 5 R/W bit of last match, 6 START seen last, 7 STOP seen last. After reset the status reads 0x00, control reads 0x02, own address reads 0x00, neither output enable is active and irq is low.
- R2: An address byte whose bits 7:1 equal the own address is acknowledged on the ninth clock. The whole byte is then loaded into the buffer, buffer full is set and the interrupt is raised at the ninth falling edge. An address that does not match gets no acknowledge and raises no interrupt.
- R3: Address 0x00 is acknowledged and raises the interrupt only while general-call enable is set.
- R4: Data bytes of a write transfer are acknowledged and loaded into the buffer. The data flag reads 1 after a data byte and 0 after an address byte. The R/W flag holds bit 0 of the last matched address byte.
- R5: If buffer full or overflow is already set when a byte completes, no acknowledge is driven and the buffer keeps its old contents. The overflow flag is set and the interrupt is still raised.
- R6: Reading the data buffer clears buffer full. Overflow, write collision and interrupt are cleared only by writing 1 to their status bits.
- R7: In a read transfer, SCL is held low after the ninth clock of the address byte, whatever the stretch-enable setting, until software sets clock release. Transmit bits go out MSB first and change only while SCL is low.
- R8: A NACK from the master after a transmitted byte ends the transfer. The block releases both lines, does not hold SCL, and ignores further clocks until the next START.
- R9: In a write transfer with stretch enable set, clock release is cleared at the ninth falling edge whenever buffer full is set, which holds SCL low until software writes the control register. With stretch enable clear, no hold occurs during a write transfer.
- R10: A write to the data buffer while a byte is being shifted out sets write collision and leaves the byte on the wire unchanged.
- R11: A START sets START-seen and clears STOP-seen. A STOP does the reverse. Each raises the interrupt when START/STOP interrupt enable is set. Clearing enable clears both bits.
- R12: A START in the middle of a byte drops that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad input level |
| sda_i | input | 1 | SDA pad input level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt flag level |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This lengthens the delay between a pad edge and the response of the protocol logic. The bench master uses a quarter period of ten system clocks, so the acknowledge, transmit-bit and SCL-hold reactions all have to land inside the low phase of SCL even with the slower synchronizer. This places the ordering of START detection against data changes, and the start of the hold after the ninth falling edge, at realistic margins instead of ones that are trivially wide.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_OWN  = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shr;
        logic [BYTE_W-1:0]   txr;
        logic [BYTE_W-1:0]   rbuf;
        logic [ADDR_W-1:0]   own;
        logic                en;
        logic                rel;
        logic                str_en;
        logic                gc_en;
        logic                ss_en;
        logic                full;
        logic                ovf;
        logic                wcol;
        logic                irq;
        logic                dna;
        logic                rw;
        logic                st_seen;
        logic                sp_seen;
        logic                ack_drv;
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] sh_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q   <= '1;
                prev_q <= 1'b1;
            end else begin
                sh_q   <= {sh_q[STAGES-2:0], raw[i]};
                prev_q <= sh_q[STAGES-1];
            end
        end

        assign lvl[i]  = sh_q[STAGES-1];
        assign rise[i] = sh_q[STAGES-1] & ~prev_q;
        assign fall[i] = ~sh_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
    import i2c_tgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_l,
    input  logic        scl_r,
    input  logic        scl_f,
    input  logic        sda_l,
    input  logic        sda_r,
    input  logic        sda_f,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        full_o,
    output logic        ovf_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(BYTE_W - 1);

    tgt_state_t st_q, st_d;

    logic start_ev, stop_ev, tx_busy, hit;

    always_comb begin
        st_d     = st_q;
        start_ev = st_q.en && sda_f && scl_l;
        stop_ev  = st_q.en && sda_r && scl_l;
        tx_busy  = (st_q.ph == PH_TX) && st_q.rel;
        hit      = (st_q.shr[BYTE_W-1:1] == st_q.own) ||
                   (st_q.gc_en && (st_q.shr[BYTE_W-1:1] == '0));

        // host side effects
        if (reg_rd && reg_addr == OFS_DATA) begin
            st_d.full = 1'b0;
        end
        if (reg_wr) begin
            case (reg_addr)
                OFS_DATA: begin
                    if (tx_busy) begin
                        st_d.wcol = 1'b1;
                    end else begin
                        st_d.txr  = reg_wdata;
                        st_d.full = 1'b1;
                    end
                end
                OFS_OWN:  st_d.own = reg_wdata[ADDR_W-1:0];
                OFS_CTRL: begin
                    st_d.en     = reg_wdata[0];
                    st_d.rel    = reg_wdata[1];
                    st_d.str_en = reg_wdata[2];
                    st_d.gc_en  = reg_wdata[3];
                    st_d.ss_en  = reg_wdata[4];
                end
                default: begin
                    if (reg_wdata[1]) st_d.ovf  = 1'b0;
                    if (reg_wdata[2]) st_d.wcol = 1'b0;
                    if (reg_wdata[3]) st_d.irq  = 1'b0;
                end
            endcase
        end

        // bus protocol
        if (!st_q.en) begin
            st_d.ph      = PH_IDLE;
            st_d.cnt     = '0;
            st_d.ack_drv = 1'b0;
            st_d.st_seen = 1'b0;
            st_d.sp_seen = 1'b0;
        end else if (start_ev) begin
            st_d.ph      = PH_ADDR;
            st_d.cnt     = '0;
            st_d.ack_drv = 1'b0;
            st_d.st_seen = 1'b1;
            st_d.sp_seen = 1'b0;
            if (st_q.ss_en) st_d.irq = 1'b1;
        end else if (stop_ev) begin
            st_d.ph      = PH_IDLE;
            st_d.cnt     = '0;
            st_d.ack_drv = 1'b0;
            st_d.st_seen = 1'b0;
            st_d.sp_seen = 1'b1;
            if (st_q.ss_en) st_d.irq = 1'b1;
        end else begin
            case (st_q.ph)
                PH_ADDR, PH_RX: begin
                    if (scl_r) begin
                        st_d.shr = {st_q.shr[BYTE_W-2:0], sda_l};
                        st_d.cnt = st_q.cnt + 1'b1;
                    end else if (scl_f && st_q.cnt == LAST_CNT) begin
                        if (st_q.ph == PH_ADDR && !hit) begin
                            st_d.ph = PH_IDLE;
                        end else begin
                            if (st_q.ph == PH_ADDR) begin
                                st_d.ph  = PH_ADDR_ACK;
                                st_d.rw  = st_q.shr[0];
                                st_d.dna = 1'b0;
                            end else begin
                                st_d.ph  = PH_RX_ACK;
                                st_d.dna = 1'b1;
                            end
                            if (!st_q.full && !st_q.ovf) begin
                                st_d.rbuf    = st_q.shr;
                                st_d.full    = 1'b1;
                                st_d.ack_drv = 1'b1;
                            end else begin
                                st_d.ovf = 1'b1;
                            end
                        end
                    end
                end
                PH_ADDR_ACK, PH_RX_ACK: begin
                    if (scl_f) begin
                        st_d.ack_drv = 1'b0;
                        st_d.irq     = 1'b1;
                        st_d.cnt     = '0;
                        if (!st_q.ack_drv) begin
                            st_d.ph = PH_IDLE;
                        end else if (st_q.ph == PH_ADDR_ACK && st_q.rw) begin
                            st_d.ph  = PH_TX;
                            st_d.rel = 1'b0;
                        end else begin
                            st_d.ph = PH_RX;
                            if (st_q.str_en && st_d.full) st_d.rel = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_f) begin
                        if (st_q.cnt == TX_LAST) begin
                            st_d.ph   = PH_TX_ACK;
                            st_d.cnt  = '0;
                            st_d.full = 1'b0;
                        end else begin
                            st_d.txr = {st_q.txr[BYTE_W-2:0], 1'b0};
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_r) begin
                        if (sda_l) st_d.ph = PH_IDLE;
                    end else if (scl_f) begin
                        st_d.irq = 1'b1;
                        st_d.dna = 1'b1;
                        st_d.ph  = PH_TX;
                        st_d.cnt = '0;
                        if (!st_d.full) st_d.rel = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ph  <= PH_IDLE;
            st_q.rel <= 1'b1;
            st_q.txr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_DATA: reg_rdata = st_q.rbuf;
            OFS_OWN:  reg_rdata = {1'b0, st_q.own};
            OFS_CTRL: reg_rdata = {3'b000, st_q.ss_en, st_q.gc_en, st_q.str_en,
                                   st_q.rel, st_q.en};
            default:  reg_rdata = {st_q.sp_seen, st_q.st_seen, st_q.rw, st_q.dna,
                                   st_q.irq, st_q.wcol, st_q.ovf, st_q.full};
        endcase
    end

    assign irq    = st_q.irq;
    assign scl_oe = st_q.en && !st_q.rel;
    assign sda_oe = st_q.en && (st_q.ack_drv ||
                    (st_q.ph == PH_TX && !st_q.txr[BYTE_W-1]));
    assign full_o = st_q.full;
    assign ovf_o  = st_q.ovf;

endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    logic [1:0] lvl_w, rise_w, fall_w;
    logic       scl_lvl;
    logic       stat_full, stat_ovf;

    i2c_line_sync #(
        .N      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_i, scl_i}),
        .lvl   (lvl_w),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    assign scl_lvl = lvl_w[0];

    i2c_tgt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_l     (lvl_w[0]),
        .scl_r     (rise_w[0]),
        .scl_f     (fall_w[0]),
        .sda_l     (lvl_w[1]),
        .sda_r     (rise_w[1]),
        .sda_f     (fall_w[1]),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .full_o    (stat_full),
        .ovf_o     (stat_ovf)
    );

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_l,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq,
    input logic       full,
    input logic       ovf
);

    logic clr_irq_wr, clr_ovf_wr, ctrl_wr;
    assign clr_irq_wr = reg_wr && reg_addr == OFS_STAT && reg_wdata[3];
    assign clr_ovf_wr = reg_wr && reg_addr == OFS_STAT && reg_wdata[1];
    assign ctrl_wr    = reg_wr && reg_addr == OFS_CTRL;

    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(full)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_irq_wr |=> irq); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr_ovf_wr |=> ovf); // R6

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(!scl_l)); // R7

    AST_HOLD_UNTIL_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && !ctrl_wr |=> scl_oe); // R9

endmodule

bind i2c_target i2c_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_l     (scl_lvl),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq),
    .full      (stat_full),
    .ovf       (stat_ovf)
);

// File: tb/tb_i2c_target.sv
module tb_i2c_target;

    localparam int QC = 10;
    localparam logic [1:0] A_DATA = 2'd0, A_OWN = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;
    localparam logic [6:0] OWN = 7'h52;

    // {address[6:0], general-call enable, expected ack, data[7:0]}
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        {7'h52, 1'b0, 1'b1, 8'hA5},
        {7'h53, 1'b0, 1'b0, 8'h00},
        {7'h00, 1'b0, 1'b0, 8'h00},
        {7'h00, 1'b1, 1'b1, 8'h3C},
        {7'h52, 1'b1, 1'b1, 8'hFF},
        {7'h29, 1'b1, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       bus_scl, bus_sda;
    int         n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    assign bus_scl = scl_m & ~scl_oe;
    assign bus_sda = sda_m & ~sda_oe;

    i2c_target #(.SYNC_STAGES(3)) dut (
        .clk (clk), .rst_n (rst_n), .scl_i (bus_scl), .sda_i (bus_sda),
        .scl_oe (scl_oe), .sda_oe (sda_oe), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_high;
        while (bus_scl !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; cyc(QC);
        scl_m = 1'b1; wait_high; cyc(2*QC);
        sda_m = 1'b0; cyc(2*QC);
        scl_m = 1'b0; cyc(QC);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; cyc(QC);
        scl_m = 1'b1; wait_high; cyc(2*QC);
        sda_m = 1'b1; cyc(2*QC);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b; cyc(QC);
        scl_m = 1'b1; wait_high; cyc(QC);
        r = bus_sda; cyc(QC);
        scl_m = 1'b0; cyc(QC);
    endtask

    task automatic m_byte_w(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_byte_r(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            v[i] = r;
        end
        m_bit(~give_ack, r);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] s, b;
        logic       ack, r;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);

        // R1: reset state
        hread(A_STAT, s); chk("R1 status", s, 8'h00);
        hread(A_CTRL, s); chk("R1 control", s, 8'h02);
        hread(A_OWN, s);  chk("R1 own", s, 8'h00);
        chk("R1 pads/irq", {5'd0, scl_oe, sda_oe, irq}, 8'h00);
        hwrite(A_OWN, {1'b0, OWN});

        // table of write transfers: R2, R3, R4, R9, R11
        for (int k = 0; k < NV; k++) begin
            logic [16:0] v;
            v = VEC[k];
            hwrite(A_STAT, 8'h0E);
            hwrite(A_CTRL, {4'b0000, v[9], 3'b011});
            m_start;
            m_byte_w({v[16:10], 1'b0}, ack);
            chk(v[9] ? "R3 addr ack" : "R2 addr ack", {7'd0, ack}, {7'd0, v[8]});
            if (v[8]) begin
                chk("R9 no hold without stretch", {7'd0, scl_oe}, 8'h00);
                hread(A_STAT, s); chk("R2 status after addr", s & 8'h39, 8'h09);
                hread(A_DATA, b); chk("R2 buffer holds addr", b, {v[16:10], 1'b0});
                hwrite(A_STAT, 8'h08);
                m_byte_w(v[7:0], ack);
                chk("R4 data ack", {7'd0, ack}, 8'h01);
                hread(A_STAT, s); chk("R4 status after data", s & 8'h31, 8'h11);
                hread(A_DATA, b); chk("R4 data buffer", b, v[7:0]);
            end else begin
                hread(A_STAT, s); chk("R2 no irq on miss", s & 8'h09, 8'h00);
            end
            m_stop;
            hread(A_STAT, s); chk("R11 stop seen", s & 8'hC0, 8'h80);
        end

        // R5 / R6: overflow handling
        hwrite(A_CTRL, 8'h03);
        hwrite(A_STAT, 8'h0E);
        m_start;
        m_byte_w({OWN, 1'b0}, ack); chk("R5 addr ack", {7'd0, ack}, 8'h01);
        m_byte_w(8'h11, ack);       chk("R5 nack when full", {7'd0, ack}, 8'h00);
        hread(A_STAT, s); chk("R5 ovf+irq+full", s & 8'h0F, 8'h0B);
        m_stop;
        hread(A_DATA, b); chk("R5 buffer kept", b, {OWN, 1'b0});
        hread(A_STAT, s); chk("R6 read clears only full", s & 8'h0F, 8'h0A);
        m_start;
        m_byte_w({OWN, 1'b0}, ack); chk("R5 nack while ovf", {7'd0, ack}, 8'h00);
        m_stop;
        hwrite(A_STAT, 8'h0A);
        hread(A_STAT, s); chk("R6 w1c clears", s & 8'h0F, 8'h00);

        // R9: stretch during write
        hwrite(A_CTRL, 8'h07);
        m_start;
        m_byte_w({OWN, 1'b0}, ack); chk("R9 addr ack", {7'd0, ack}, 8'h01);
        chk("R9 hold when full", {7'd0, scl_oe}, 8'h01);
        hread(A_CTRL, s); chk("R9 release cleared", s, 8'h05);
        cyc(3 * QC);
        chk("R9 hold persists", {7'd0, scl_oe}, 8'h01);
        hread(A_DATA, b);
        hwrite(A_CTRL, 8'h07);
        chk("R9 hold dropped", {7'd0, scl_oe}, 8'h00);
        m_byte_w(8'h66, ack); chk("R9 data ack", {7'd0, ack}, 8'h01);
        chk("R9 hold after data", {7'd0, scl_oe}, 8'h01);
        hread(A_DATA, b); chk("R9 data", b, 8'h66);
        hwrite(A_CTRL, 8'h07);
        m_stop;

        // R7 / R10 / R8: read transfer
        hwrite(A_CTRL, 8'h03);
        hwrite(A_STAT, 8'h0E);
        m_start;
        m_byte_w({OWN, 1'b1}, ack); chk("R7 read addr ack", {7'd0, ack}, 8'h01);
        chk("R7 hold without stretch", {7'd0, scl_oe}, 8'h01);
        hread(A_STAT, s); chk("R4 rw flag", s & 8'h30, 8'h20);
        hread(A_DATA, b);
        hwrite(A_DATA, 8'hC3);
        hwrite(A_CTRL, 8'h03);
        m_byte_r(1'b1, b); chk("R7 tx byte", b, 8'hC3);
        chk("R7 hold for next", {7'd0, scl_oe}, 8'h01);
        hwrite(A_DATA, 8'h5A);
        hwrite(A_CTRL, 8'h03);
        for (int i = 7; i >= 5; i--) begin
            m_bit(1'b1, r); b[i] = r;
        end
        hwrite(A_DATA, 8'h77);
        for (int i = 4; i >= 0; i--) begin
            m_bit(1'b1, r); b[i] = r;
        end
        m_bit(1'b1, r);
        chk("R10 byte unchanged", b, 8'h5A);
        hread(A_STAT, s); chk("R10 collision", s & 8'h04, 8'h04);
        chk("R8 no hold after nack", {7'd0, scl_oe}, 8'h00);
        m_byte_r(1'b0, b); chk("R8 ignored clocks", b, 8'hFF);
        chk("R8 lines free", {6'd0, scl_oe, sda_oe}, 8'h00);
        m_stop;

        // R11: start/stop flags and interrupts
        hwrite(A_CTRL, 8'h13);
        hwrite(A_STAT, 8'h0E);
        m_start;
        chk("R11 irq on start", {7'd0, irq}, 8'h01);
        hread(A_STAT, s); chk("R11 start seen", s & 8'hC0, 8'h40);
        hwrite(A_STAT, 8'h08);
        m_stop;
        chk("R11 irq on stop", {7'd0, irq}, 8'h01);
        hread(A_STAT, s); chk("R11 stop only", s & 8'hC0, 8'h80);
        hwrite(A_CTRL, 8'h00);
        hread(A_STAT, s); chk("R11 cleared by disable", s & 8'hC0, 8'h00);

        // R12: START mid-byte restarts address reception
        hwrite(A_CTRL, 8'h03);
        hwrite(A_STAT, 8'h0E);
        hread(A_DATA, b);
        m_start;
        for (int i = 0; i < 4; i++) m_bit(1'b1, r);
        m_start;
        m_byte_w({OWN, 1'b0}, ack); chk("R12 ack after restart", {7'd0, ack}, 8'h01);
        hread(A_DATA, b); chk("R12 buffer", b, {OWN, 1'b0});
        m_stop;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule